// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the byte-wide host-facing register window of an audio codec. A host reaches it through four directly addressed ports: an index port, an indexed-data port that reaches a bank of indirect control registers, a status port, and a programmed-I/O data port. Only the low 16 indirect registers can be reached in legacy mode. Setting a mode bit widens the index so that all 32 can be reached.

The block guards the sample-format register behind a mode-change-enable bit in the index port. A partial-update enable lets the host change only the upper nibble of that register. Reserved and read-only registers are protected from writes. After the mode-change-enable bit rises, the block shows a short calibration-in-progress flag. It also acknowledges interrupts. A separate playback counter reports interrupts through `irq_set`. In return, this block drives the current format, configuration and base-count registers to that counter.

Top module: `codec_regport`

## Requirements
- R1: Port select 0 is the index port, 1 is indexed data, 2 is status and 3 is PIO data. The index register resets to 0x40, so mode-change-enable (index bit 6) is set out of reset. Index bit 7 is dropped on every write and always reads as 0.
- R2: The indirect address is index bits 3:0 while bit 6 of indirect register 12 is 0. It is index bits 4:0 while that bit is 1.
- R3: After reset, registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80, register 9 reads 0x08, register 12 reads 0x8A, and registers 25 and 26 read 0xA0. Every other register reads 0x00.
- R4: Writes to registers 21, 27 and 29 are discarded, and register 11 cannot be written. In register 12 a write changes only bit 6.
- R5: A write to register 8 is taken whole when index bit 6 is 1. When index bit 6 is 0 and bit 4 of register 24 is 1, the write updates only bits 7:4 and bits 3:0 keep their old value. When both are 0, the write has no effect.
- R6: Bit 5 of register 9 is always stored as 0, whatever value is written.
- R7: An index write that takes index bit 6 from 0 to 1, while register 9 bits 4:3 are nonzero, loads a calibration counter with CAL_LOAD. While the counter is nonzero, each data-port read of register 11 returns bit 5 set and decrements the counter.
- R8: Any write to the status port clears status bit 0 and bits 4, 5 and 6 of register 24, and it drops `irq_out`.
- R9: A write to register 24 that clears bit 4 while that bit was 1 clears status bit 0 and drops `irq_out`.
- R10: `irq_set` sets status bit 0, bit 4 of register 24 and `irq_out` at the next clock edge. When a clear arrives in the same cycle, the set wins.
- R11: Writes to the PIO data port are ignored, and that port reads 0x00. Reads of the index, status and PIO ports, and data-port reads of registers other than 11, change no state.
- R12: `fmt_o` mirrors register 8 and `cfg_o` mirrors register 9. `count_o` is {register 14, register 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Direct port select |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (side effects only) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected port (combinational) |
| irq_set | input | 1 | Playback-interrupt request from the playback counter |
| irq_out | output | 1 | Interrupt line |
| fmt_o | output | 8 | Current rate/format register |
| cfg_o | output | 8 | Current configuration register |
| count_o | output | 16 | Playback base count {upper, lower} |

## Verification
The hardest state to reach is the calibration flag. It needs the index port's enable bit to be lowered and raised again, and it needs register 9 to hold nonzero bits 4:3 at the moment of the rising write. The bench drops the enable, programs register 9, and raises the enable with the index aimed at register 11. It then reads register 11 back to back and counts how many reads show the flag.

The partial-update path needs register 24 bit 4 set while the enable is clear. The same-cycle set-versus-acknowledge case needs `irq_set` and a status write on one edge. The bench drives both cases explicitly. Full write/read sweeps over all 32 registers, in both index widths, check every protection rule against a bench-side model.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;

   localparam int unsigned DW    = 8;
   localparam int unsigned NREG  = 32;
   localparam int unsigned AW    = $clog2(NREG);

   typedef logic [DW-1:0] byte_t;

   typedef enum logic [1:0] {
      PORT_INDEX = 2'd0,
      PORT_DATA  = 2'd1,
      PORT_STAT  = 2'd2,
      PORT_PIO   = 2'd3
   } port_e;

   localparam logic [AW-1:0] REG_FMT   = 5'd8;
   localparam logic [AW-1:0] REG_CFG   = 5'd9;
   localparam logic [AW-1:0] REG_INIT  = 5'd11;
   localparam logic [AW-1:0] REG_MODE  = 5'd12;
   localparam logic [AW-1:0] REG_CNTH  = 5'd14;
   localparam logic [AW-1:0] REG_CNTL  = 5'd15;
   localparam logic [AW-1:0] REG_ASTAT = 5'd24;

   localparam int unsigned MCE_BIT   = 6;
   localparam int unsigned MODE2_BIT = 6;
   localparam int unsigned PMCE_BIT  = 4;
   localparam int unsigned PI_BIT    = 4;
   localparam byte_t       IRQ_FLAGS = 8'h70;
   localparam byte_t       CAL_FLAG  = 8'h20;

   function automatic byte_t reset_val(input logic [AW-1:0] k);
      case (k)
         5'd2, 5'd3, 5'd4, 5'd5, 5'd18, 5'd19: reset_val = 8'h88;
         5'd6, 5'd7:                           reset_val = 8'h80;
         5'd9:                                 reset_val = 8'h08;
         5'd12:                                reset_val = 8'h8A;
         5'd25, 5'd26:                         reset_val = 8'hA0;
         default:                              reset_val = 8'h00;
      endcase
   endfunction

   function automatic byte_t merge_write(input logic [AW-1:0] k, input byte_t old,
                                         input byte_t d, input logic mce, input logic pmce);
      case (k)
         5'd11, 5'd21, 5'd27, 5'd29: merge_write = old;
         5'd12:  merge_write = {old[7], d[6], old[5:0]};
         5'd8:   merge_write = mce  ? d :
                               pmce ? {d[7:4], old[3:0]} : old;
         5'd9:   merge_write = d & ~CAL_FLAG;
         default: merge_write = d;
      endcase
   endfunction

endpackage

// File: rtl/codec_idx_decode.sv
module codec_idx_decode
   import codec_regport_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_idx,
   input  byte_t         wr_data,
   input  logic          mode2,
   output byte_t         idx_q,
   output logic          mce,
   output logic          mce_rise,
   output logic [AW-1:0] addr
);
   localparam int unsigned LEG_AW = AW - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= 8'h40;
      else if (wr_idx) idx_q <= {1'b0, wr_data[DW-2:0]};
   end

   assign mce      = idx_q[MCE_BIT];
   assign mce_rise = wr_idx && !idx_q[MCE_BIT] && wr_data[MCE_BIT];
   assign addr     = mode2 ? idx_q[AW-1:0] : {1'b0, idx_q[LEG_AW-1:0]};
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
   import codec_regport_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_hit,
   input  logic [AW-1:0]           waddr,
   input  byte_t                   wdata,
   input  logic                    mce,
   input  logic                    stat_clr,
   input  logic                    irq_set,
   output logic [NREG-1:0][DW-1:0] regs_o
);
   logic pmce;
   assign pmce = regs_o[REG_ASTAT][PMCE_BIT];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [AW-1:0] K = g;
      byte_t q, d_n;

      always_comb begin
         d_n = q;
         if (wr_hit && waddr == K) d_n = merge_write(K, q, wdata, mce, pmce);
         if (K == REG_ASTAT) begin
            if (stat_clr) d_n = d_n & ~IRQ_FLAGS;
            if (irq_set)  d_n[PI_BIT] = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= reset_val(K);
         else        q <= d_n;
      end

      assign regs_o[g] = q;
   end
endmodule

// File: rtl/codec_cal_timer.sv
module codec_cal_timer #(
   parameter int unsigned CAL_LOAD = 1,
   localparam int unsigned CW      = $clog2(CAL_LOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dec,
   output logic busy
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= CW'(CAL_LOAD);
      else if (dec && busy)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/codec_irq_ctl.sv
module codec_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_set,
   input  logic clr,
   output logic int_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       int_q <= 1'b0;
      else if (irq_set) int_q <= 1'b1;
      else if (clr)     int_q <= 1'b0;
   end
endmodule

// File: rtl/codec_regport.sv
module codec_regport
   import codec_regport_pkg::*;
#(
   parameter int unsigned CAL_LOAD = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  port_sel,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   input  logic        irq_set,
   output logic        irq_out,
   output logic [7:0]  fmt_o,
   output logic [7:0]  cfg_o,
   output logic [15:0] count_o
);
   if (CAL_LOAD < 1) begin : g_bad_cal
      $error("CAL_LOAD must be at least 1");
   end

   logic [NREG-1:0][DW-1:0] regs;
   byte_t          idx_q;
   logic           mce, mce_rise, pmce, cal_busy, int_q;
   logic [AW-1:0]  waddr;
   logic           wr_idx, wr_dat, wr_stat, rd_init, pi_drop, stat_clr;

   assign wr_idx  = wr_en && port_sel == PORT_INDEX;
   assign wr_dat  = wr_en && port_sel == PORT_DATA;
   assign wr_stat = wr_en && port_sel == PORT_STAT;
   assign rd_init = rd_en && port_sel == PORT_DATA && waddr == REG_INIT;
   assign pmce    = regs[REG_ASTAT][PMCE_BIT];
   assign pi_drop = wr_dat && waddr == REG_ASTAT && regs[REG_ASTAT][PI_BIT] && !wr_data[PI_BIT];
   assign stat_clr = wr_stat;

   codec_idx_decode u_idx (
      .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wr_data(wr_data),
      .mode2(regs[REG_MODE][MODE2_BIT]), .idx_q(idx_q), .mce(mce),
      .mce_rise(mce_rise), .addr(waddr)
   );

   codec_ireg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_dat), .waddr(waddr), .wdata(wr_data),
      .mce(mce), .stat_clr(stat_clr), .irq_set(irq_set), .regs_o(regs)
   );

   codec_cal_timer #(.CAL_LOAD(CAL_LOAD)) u_cal (
      .clk(clk), .rst_n(rst_n),
      .load(mce_rise && regs[REG_CFG][4:3] != 2'b00),
      .dec(rd_init), .busy(cal_busy)
   );

   codec_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .irq_set(irq_set),
      .clr(wr_stat || pi_drop), .int_q(int_q)
   );

   always_comb begin
      case (port_sel)
         PORT_INDEX: rd_data = idx_q;
         PORT_DATA:  rd_data = regs[waddr] |
                               ((waddr == REG_INIT && cal_busy) ? CAL_FLAG : 8'h00);
         PORT_STAT:  rd_data = {7'b0, int_q};
         default:    rd_data = 8'h00;
      endcase
   end

   assign irq_out = int_q;
   assign fmt_o   = regs[REG_FMT];
   assign cfg_o   = regs[REG_CFG];
   assign count_o = {regs[REG_CNTH], regs[REG_CNTL]};
endmodule

// File: rtl/codec_regport_chk.sv
module codec_regport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] port_sel,
   input logic       wr_en,
   input logic [7:0] rd_data,
   input logic       irq_set,
   input logic       irq_out,
   input logic [7:0] fmt_o,
   input logic [7:0] cfg_o,
   input logic       mce,
   input logic       pmce,
   input logic [4:0] waddr
);
   p_idx_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (port_sel == 2'd0) |-> (rd_data[7] == 1'b0));

   p_fmt_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel == 2'd1 && waddr == 5'd8 && !mce && !pmce) |=> $stable(fmt_o));

   p_fmt_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel == 2'd1 && waddr == 5'd8 && !mce && pmce)
      |=> (fmt_o[3:0] == $past(fmt_o[3:0])));

   p_cfg_rsv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_o[5] == 1'b0);

   p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel == 2'd2 && !irq_set) |=> !irq_out);

   p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq_out);
endmodule

bind codec_regport codec_regport_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_data(rd_data),
   .irq_set(irq_set), .irq_out(irq_out), .fmt_o(fmt_o), .cfg_o(cfg_o),
   .mce(mce), .pmce(pmce), .waddr(waddr)
);

// File: tb/codec_regport_tb_top.sv
`timescale 1ns/1ps
module codec_regport_tb_top;
   localparam int CAL = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  port_sel = 2'd0;
   logic        wr_en = 1'b0, rd_en = 1'b0, irq_set = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data, fmt_o, cfg_o;
   logic [15:0] count_o;
   logic        irq_out;

   int checks = 0, errors = 0;
   logic [7:0] er [32];
   logic [7:0] eidx;
   int         ecnt;
   logic       eint;

   always #10 clk = ~clk;

   codec_regport #(.CAL_LOAD(CAL)) dut_i (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_set(irq_set), .irq_out(irq_out),
      .fmt_o(fmt_o), .cfg_o(cfg_o), .count_o(count_o)
   );

   function automatic logic [7:0] rst_model(input int k);
      if (k inside {2, 3, 4, 5, 18, 19}) return 8'h88;
      if (k == 6 || k == 7)              return 8'h80;
      if (k == 9)                        return 8'h08;
      if (k == 12)                       return 8'h8A;
      if (k == 25 || k == 26)            return 8'hA0;
      return 8'h00;
   endfunction

   function automatic int cur_addr();
      return er[12][6] ? int'(eidx[4:0]) : int'(eidx[3:0]);
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] p, input logic [7:0] d);
      int a;
      case (p)
         2'd0: begin
            if (!eidx[6] && d[6] && er[9][4:3] != 2'b00) ecnt = CAL;
            eidx = d & 8'h7F;
         end
         2'd1: begin
            a = cur_addr();
            if (a == 24 && er[24][4] && !d[4]) eint = 1'b0;
            if (a inside {11, 21, 27, 29}) ;
            else if (a == 12) er[12][6] = d[6];
            else if (a == 8) begin
               if (eidx[6]) er[8] = d;
               else if (er[24][4]) er[8] = {d[7:4], er[8][3:0]};
            end
            else if (a == 9) er[9] = d & 8'hDF;
            else er[a] = d;
         end
         2'd2: begin
            eint = 1'b0;
            er[24] = er[24] & 8'h8F;
         end
         default: ;
      endcase
      @(negedge clk);
      port_sel = p; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] p, input string tag);
      logic [7:0] exp;
      int a;
      a = cur_addr();
      case (p)
         2'd0: exp = eidx;
         2'd1: exp = er[a] | ((a == 11 && ecnt != 0) ? 8'h20 : 8'h00);
         2'd2: exp = {7'b0, eint};
         default: exp = 8'h00;
      endcase
      @(negedge clk);
      port_sel = p; rd_en = 1'b1;
      #1;
      chk(16'(rd_data), 16'(exp), tag);
      @(negedge clk);
      rd_en = 1'b0;
      if (p == 2'd1 && a == 11 && ecnt != 0) ecnt--;
   endtask

   task automatic rd_reg(input int k, input string tag);
      wr(2'd0, 8'(k) | (eidx & 8'h40));
      rd(2'd1, tag);
   endtask

   task automatic pulse_irq(input logic with_stat);
      @(negedge clk);
      irq_set = 1'b1;
      if (with_stat) begin port_sel = 2'd2; wr_en = 1'b1; end
      @(negedge clk);
      irq_set = 1'b0; wr_en = 1'b0;
      if (with_stat) er[24] = er[24] & 8'h8F;
      er[24][4] = 1'b1;
      eint = 1'b1;
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 32; k++) er[k] = rst_model(k);
      eidx = 8'h40; ecnt = 0; eint = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R11: reset state, repeated idle reads
      rd(2'd0, "R1 index reset");
      rd(2'd0, "R11 index reread");
      rd(2'd2, "R3 status reset");
      chk(16'(irq_out), 16'h0, "R3 irq reset");
      rd(2'd3, "R11 pio reset");
      for (int k = 0; k < 16; k++) rd_reg(k, "R3 legacy reset sweep");
      wr(2'd0, 8'h4C);
      wr(2'd1, 8'hFF);                  // R4: only bit 6 of reg 12 changes
      rd(2'd1, "R4 reg12 bit6 only");
      for (int k = 0; k < 32; k++) rd_reg(k, "R3 extended reset sweep");

      // R1: index msb dropped
      wr(2'd0, 8'hFF);
      rd(2'd0, "R1 index bit7");

      // R4 R6 R12: two write/read sweeps in extended mode
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 32; k++) begin
            logic [7:0] v;
            v = 8'((k * 37 + 5) ^ (pass * 8'hFF));
            if (k == 12) v = v | 8'h40;
            wr(2'd0, 8'h40 | 8'(k));
            wr(2'd1, v);
         end
         for (int k = 0; k < 32; k++) rd_reg(k, "R4 R6 sweep readback");
         chk(16'(fmt_o), 16'(er[8]), "R12 fmt_o");
         chk(16'(cfg_o), 16'(er[9]), "R12 cfg_o");
         chk(count_o, {er[14], er[15]}, "R12 count_o");
         chk(16'(irq_out), 16'(eint), "R9 irq after sweep");
      end

      // R6: reserved bit forced low
      wr(2'd0, 8'h49); wr(2'd1, 8'hFF);
      rd(2'd1, "R6 reg9 bit5");

      // R2: legacy aliasing
      wr(2'd0, 8'h4C); wr(2'd1, 8'h00);
      wr(2'd0, 8'h53); wr(2'd1, 8'h5A);
      rd(2'd1, "R2 legacy alias read");
      wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
      rd_reg(19, "R2 reg19 untouched");
      rd_reg(3, "R2 reg3 written");

      // R5: format gating
      wr(2'd0, 8'h58); wr(2'd1, 8'h00);
      wr(2'd0, 8'h08); wr(2'd1, 8'hA5);
      chk(16'(fmt_o), 16'(er[8]), "R5 format ignored");
      wr(2'd0, 8'h18); wr(2'd1, 8'h10);
      wr(2'd0, 8'h08); wr(2'd1, 8'h3C);
      chk(16'(fmt_o), 16'(er[8]), "R5 format partial");
      wr(2'd0, 8'h48); wr(2'd1, 8'hC3);
      chk(16'(fmt_o), 16'h00C3, "R5 format full");

      // R7: calibration flag
      wr(2'd0, 8'h0B); wr(2'd1, 8'hFF);    // R4: reg 11 read-only
      wr(2'd0, 8'h09); wr(2'd1, 8'h18);
      wr(2'd0, 8'h4B);
      rd(2'd1, "R7 cal read 1");
      rd(2'd1, "R7 cal read 2");
      rd(2'd1, "R7 cal expired");
      wr(2'd0, 8'h09); wr(2'd1, 8'h00);
      wr(2'd0, 8'h4B);
      rd(2'd1, "R7 no cal when cfg zero");

      // R8 R9 R10: interrupt handling
      wr(2'd0, 8'h58); wr(2'd1, 8'h00);
      pulse_irq(1'b0);
      chk(16'(irq_out), 16'h1, "R10 irq set");
      rd(2'd2, "R10 status int");
      rd(2'd1, "R10 reg24 bit4");
      wr(2'd2, 8'h00);
      chk(16'(irq_out), 16'h0, "R8 status ack");
      rd(2'd1, "R8 reg24 cleared");
      pulse_irq(1'b0);
      wr(2'd1, 8'h00);
      chk(16'(irq_out), 16'h0, "R9 reg24 drop");
      rd(2'd2, "R9 status cleared");
      wr(2'd1, 8'h60);
      pulse_irq(1'b1);
      chk(16'(irq_out), 16'h1, "R10 set wins");
      rd(2'd1, "R10 set wins reg24");

      // R11: PIO writes ignored
      wr(2'd3, 8'hFF);
      rd(2'd3, "R11 pio ignored");
      rd(2'd0, "R11 index unchanged");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule